// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block is a synchronous controller that runs write cycles on a byte-wide asynchronous static memory with a 19-bit address. A client hands it one address and one data byte over a valid/ready handshake. The sequencer then drives the chip-enable, write-enable and output-enable strobes and the data bus with the timing the memory needs. Every interval is a whole number of clock cycles set by a parameter.

A mode bit, captured together with the request, selects how the write is shaped. With the mode bit at 0 the write is write-enable controlled: chip enable drops for the whole cycle and write enable delivers the pulse inside it. With the mode bit at 1 the write is chip-enable controlled: write enable drops for the whole cycle and chip enable delivers the pulse.

Each write has five phases in a fixed order: address setup, strobe pulse, hold, recovery, and back to idle. The data bus is a driver value plus a drive enable, for a tri-state pad at the chip edge. The enable opens late in the pulse and closes at the end of the hold. Output enable stays high at all times, because this block only writes.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is held and after it is released, the sequencer is idle. In idle, the chip-enable, write-enable and output-enable outputs are 1, the data drive enable is 0 and req_ready is 1.
- R2: A request is taken on a rising clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the recovery interval has ended. Address, data and mode inputs that change during that time have no effect on the cycle already running.
- R3: With mode 0 (write-enable controlled), chip enable is 0 for T_SETUP+T_PULSE+T_HOLD cycles, starting in the cycle after acceptance. Write enable is 0 only for the T_PULSE cycles that follow the first T_SETUP of those cycles.
- R4: With mode 1 (chip-enable controlled), write enable is 0 for T_SETUP+T_PULSE+T_HOLD cycles, starting in the cycle after acceptance. Chip enable is 0 only for the T_PULSE cycles that follow the first T_SETUP of those cycles.
- R5: Through setup, pulse and hold, mem_addr equals the captured request address and does not change.
- R6: mem_oe_n is 1 in every cycle.
- R7: The data drive enable is 1 only in two places: from pulse cycle index max(T_TURN, T_PULSE−T_DSETUP) to the end of the pulse (the index counts from 0), and through the whole hold. While the enable is 1, mem_dq_out carries the captured byte.
- R8: After the hold, all strobes stay 1 and the bus is released for T_REC_WE cycles (mode 0) or T_REC_CE cycles (mode 1), before req_ready returns to 1.
- R9: If req_valid is held at 1, the next request is taken on the first idle edge. Its setup then starts in the following cycle, so back-to-back cycles are spaced exactly by the recovery interval plus one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 19 | Write address |
| req_data | input | 8 | Write data byte |
| req_ce_mode | input | 1 | 0: write-enable controlled, 1: chip-enable controlled |
| mem_addr | output | 19 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data value for the bus pad |
| mem_dq_en | output | 1 | Bus pad drive enable |

## Verification
The bench compares every output in every cycle of each write against a timeline built from the phase lengths, in both modes. The later falling strobe and the earlier rising strobe must sit in the right places, or the memory latches a wrong window. The bench scrambles the request inputs while a write is busy. A design that does not hold its captured copy would move the address or data during the write. A back-to-back pair with valid held high shows whether the recovery gap is shortened or an extra idle cycle slips in. A reset in the middle of a write shows whether the strobes are released at once or left stuck low.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_RECOV = 3'd4
  } wr_phase_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_ln,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  logic [CW-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

  // R8
  tmr_dec_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_seq_strobe.sv
module sram_seq_strobe
  import sram_seq_pkg::*;
#(
  parameter int CW      = 3,
  parameter int DRV_CNT = 1
) (
  input  wr_phase_t     phase,
  input  logic          ce_mode,
  input  logic [CW-1:0] cnt,
  output logic          ce_n,
  output logic          we_n,
  output logic          dq_en
);

  localparam logic [CW-1:0] DRV_LIMIT = CW'(DRV_CNT);

  logic frame;
  logic pulse;

  always_comb begin
    frame = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
    pulse = (phase == PH_PULSE);
    if (ce_mode) begin
      ce_n = !pulse;
      we_n = !frame;
    end else begin
      ce_n = !frame;
      we_n = !pulse;
    end
    dq_en = (pulse && (cnt <= DRV_LIMIT)) || (phase == PH_HOLD);
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_seq_pkg::*;
#(
  parameter int AW       = 19,
  parameter int DW       = 8,
  parameter int T_SETUP  = 2,
  parameter int T_PULSE  = 4,
  parameter int T_DSETUP = 2,
  parameter int T_TURN   = 1,
  parameter int T_HOLD   = 1,
  parameter int T_REC_WE = 2,
  parameter int T_REC_CE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_ce_mode,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_en
);

  localparam int MAXT = max2(max2(max2(T_SETUP, T_PULSE), max2(T_HOLD, T_REC_WE)), T_REC_CE);
  localparam int CW = $clog2(MAXT + 1);
  localparam int DRV_START = max2(T_TURN, T_PULSE - T_DSETUP);
  localparam int DRV_CNT = T_PULSE - 1 - DRV_START;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= 2'b00;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ln = rst_pipe[1];

  wr_phase_t     ph_d, ph_q;
  logic          accept;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic [CW-1:0] tmr_cnt;
  logic          tmr_zero;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          mode_q;

  always_comb begin
    ph_d     = ph_q;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (ph_q)
      PH_IDLE: if (req_valid) begin
        accept   = 1'b1;
        ph_d     = PH_SETUP;
        tmr_load = 1'b1;
        tmr_val  = CW'(T_SETUP - 1);
      end
      PH_SETUP: if (tmr_zero) begin
        ph_d     = PH_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CW'(T_PULSE - 1);
      end
      PH_PULSE: if (tmr_zero) begin
        ph_d     = PH_HOLD;
        tmr_load = 1'b1;
        tmr_val  = CW'(T_HOLD - 1);
      end
      PH_HOLD: if (tmr_zero) begin
        ph_d     = PH_RECOV;
        tmr_load = 1'b1;
        tmr_val  = mode_q ? CW'(T_REC_CE - 1) : CW'(T_REC_WE - 1);
      end
      PH_RECOV: if (tmr_zero) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln)
      ph_q <= PH_IDLE;
    else
      ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      addr_q <= '0;
      data_q <= '0;
      mode_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
      mode_q <= req_ce_mode;
    end
  end

  sram_seq_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_ln   (rst_ln),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .zero     (tmr_zero)
  );

  sram_seq_strobe #(.CW(CW), .DRV_CNT(DRV_CNT)) i_strobe (
    .phase   (ph_q),
    .ce_mode (mode_q),
    .cnt     (tmr_cnt),
    .ce_n    (mem_ce_n),
    .we_n    (mem_we_n),
    .dq_en   (mem_dq_en)
  );

  assign req_ready  = (ph_q == PH_IDLE);
  assign mem_addr   = addr_q;
  assign mem_dq_out = data_q;
  assign mem_oe_n   = 1'b1;

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_en));

  // R2
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    ((!mem_ce_n || !mem_we_n) && $past(!mem_ce_n || !mem_we_n)) |-> $stable(mem_addr));

  // R7
  drive_after_turn_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    $rose(mem_dq_en) |-> $past(!mem_ce_n && !mem_we_n));

  // R7
  drive_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    mem_dq_en |-> (!mem_ce_n || !mem_we_n));

endmodule

// File: tb/test_sram_wr_seq.sv
`timescale 1ns/1ps
module test_sram_wr_seq;

  localparam int S = 2, P = 4, DS = 2, TURN = 1, H = 1, RWE = 2, RCE = 3;
  localparam int DSTART = (TURN > P - DS) ? TURN : P - DS;

  // {mode, addr[18:0], data[7:0]}
  localparam logic [27:0] VEC [6] = '{
    {1'b0, 19'h00000, 8'h00},
    {1'b0, 19'h7FFFF, 8'hFF},
    {1'b1, 19'h12345, 8'hA5},
    {1'b1, 19'h55555, 8'h5A},
    {1'b0, 19'h2AAAA, 8'h3C},
    {1'b1, 19'h40001, 8'h81}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [18:0] req_addr;
  logic [7:0]  req_data;
  logic        req_ce_mode;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_en;
  logic [7:0]  mem_dq_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sram_wr_seq i_sram_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_ce_mode(req_ce_mode),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_en(mem_dq_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_en, req_ready}, 5'b11101);
  endtask

  task automatic expect_cycle(input logic mode, input logic [18:0] a,
                              input logic [7:0] d, input int k);
    int  rec;
    bit  in_set, in_pul, in_hld, frame, busy, exp_ce, exp_we, exp_en;
    rec    = mode ? RCE : RWE;
    in_set = (k <= S);
    in_pul = (k > S) && (k <= S + P);
    in_hld = (k > S + P) && (k <= S + P + H);
    frame  = in_set || in_pul || in_hld;
    busy   = (k <= S + P + H + rec);
    exp_ce = mode ? !in_pul : !frame;
    exp_we = mode ? !frame : !in_pul;
    exp_en = (in_pul && (k - S - 1) >= DSTART) || in_hld;
    chk(mode ? "R4" : "R3", {mem_ce_n, mem_we_n}, {exp_ce, exp_we});
    chk("R6", mem_oe_n, 1'b1);
    chk("R7", mem_dq_en, exp_en);
    if (exp_en) chk("R7", mem_dq_out, d);
    if (frame) chk("R5", mem_addr, a);
    if (frame) chk("R2", req_ready, 1'b0);
    else if (busy) chk("R8", req_ready, 1'b0);
    else chk("R2", req_ready, 1'b1);
  endtask

  task automatic check_seq(input logic mode, input logic [18:0] a, input logic [7:0] d);
    int total;
    total = S + P + H + (mode ? RCE : RWE) + 1;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      expect_cycle(mode, a, d, k);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; req_ce_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1");

    // table walk: inputs scrambled while busy (R2 ignore)
    for (int i = 0; i < 6; i++) begin
      req_ce_mode = VEC[i][27];
      req_addr    = VEC[i][26:8];
      req_data    = VEC[i][7:0];
      req_valid   = 1'b1;
      @(posedge clk);
      #1;
      req_valid   = 1'b0;
      req_addr    = ~VEC[i][26:8];
      req_data    = ~VEC[i][7:0];
      req_ce_mode = ~VEC[i][27];
      check_seq(VEC[i][27], VEC[i][26:8], VEC[i][7:0]);
    end

    // R9: valid held high, second request waits for idle then starts at once
    req_ce_mode = 1'b0; req_addr = 19'h0F0F0; req_data = 8'h11; req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_ce_mode = 1'b1; req_addr = 19'h70707; req_data = 8'hEE;
    check_seq(1'b0, 19'h0F0F0, 8'h11);
    chk("R9", req_ready, 1'b1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check_seq(1'b1, 19'h70707, 8'hEE);

    // R1: reset in the middle of a pulse releases everything at once
    req_ce_mode = 1'b1; req_addr = 19'h33333; req_data = 8'h77; req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    for (int k = 1; k <= S + 2; k++) begin
      @(negedge clk);
      expect_cycle(1'b1, 19'h33333, 8'h77, k);
    end
    rst_n = 1'b0;
    #1;
    chk_idle("R1");
    @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1");

    // after reset a fresh write still runs the full timeline
    req_ce_mode = 1'b0; req_addr = 19'h00001; req_data = 8'h42; req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check_seq(1'b0, 19'h00001, 8'h42);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule